// File: doc/BRIEF.md
# MDIO Management Master

This block reads and writes single registers in an external Ethernet PHY over the two-wire MDC/MDIO management bus. The host presents a combined PHY/register address, selects an MDC clock ratio and then starts a transaction. A one-cycle strobe that carries the write data starts a write. A rising edge on a level read-command bit starts a read. The block raises `busy` while a frame is on the wire. When `busy` drops after a read, the 16-bit value sampled from the PHY is held on `rd_data`.

MDC is made from the system clock by one of seven fixed even ratios. MDC stays low whenever no frame is in flight. A level management-reset input aborts any frame in progress and holds the logic idle for as long as it is high.

Top module: `mdio_master`

## Requirements
- R1: After reset, and whenever no frame is active, `mdc` is low, `mdio_oe` is low, `busy` is low, and after reset `rd_data` is 0.
- R2: `div_sel` values 0..6 give an MDC period of 4, 6, 8, 10, 14, 20 and 28 system clocks, and value 7 gives 28. The high and low halves are each half the period. The selection is latched when a frame starts.
- R3: A write frame is 64 MDC cycles, sent MSB first, in this order: 32 ones, start `01`, opcode `01`, the 5-bit PHY address (`phy_reg_addr[9:5]`), the 5-bit register number (`phy_reg_addr[4:0]`), turnaround `10`, then `wr_data`. `mdio_oe` is high for all 64 bits.
- R4: `wr_strobe` in an idle cycle starts a write, and `busy` is high from the next cycle until the frame's last MDC falling edge. A write has priority when it coincides with a read start.
- R5: A read frame uses opcode `10`. `mdio_oe` is low during the two turnaround bits and the 16 data bits.
- R6: On a read, `mdio_i` is sampled on each of the 16 data-bit MDC rising edges, MSB first. The value appears on `rd_data` when `busy` falls.
- R7: A read starts only on a 0-to-1 change of `read_cmd`. Holding it high after completion starts nothing more, and clearing and setting it again starts a new read.
- R8: `wr_strobe` or a `read_cmd` rise while `busy` is high is ignored. The frame on the wire is unchanged and no second frame follows.
- R9: While `mgmt_rst` is high, any frame is aborted from the next cycle, with `busy`, `mdc` and `mdio_oe` low, and commands are ignored. Normal operation resumes once it is cleared.
- R10: `mdio_o` changes only while MDC is low, so it is stable through every MDC high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mgmt_rst | input | 1 | Level management reset; holds the logic idle |
| div_sel | input | 3 | MDC ratio select |
| phy_reg_addr | input | 10 | {PHY address, register number} |
| wr_strobe | input | 1 | One-cycle write start |
| wr_data | input | 16 | Data for a write |
| read_cmd | input | 1 | Level read command; its rising edge starts a read |
| busy | output | 1 | Transaction in progress |
| rd_data | output | 16 | Data from the last completed read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The bench builds the block with its default parameters: a 32-bit preamble, 5-bit address fields and 16-bit data, which make a 64-bit frame. At these sizes every divider ratio can be run, including the largest, where a frame takes 1792 system clocks. The bench's PHY model records all 64 MDC bits, and the model stays small. Because the real preamble length is used, the turnaround release and the data sampling fall at their true bit positions, and an abort by the management reset lands partway through a preamble.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int SEL_W    = 3;
  localparam int MAX_HALF = 14;
  localparam int HALF_W   = $clog2(MAX_HALF + 1);

  // Full MDC period in system clocks for a given select code.
  function automatic int unsigned mdc_ratio(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd0:    mdc_ratio = 4;
      3'd1:    mdc_ratio = 6;
      3'd2:    mdc_ratio = 8;
      3'd3:    mdc_ratio = 10;
      3'd4:    mdc_ratio = 14;
      3'd5:    mdc_ratio = 20;
      default: mdc_ratio = 28;
    endcase
  endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen
  import mdio_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic             mdc,
  output logic             rise_tick,
  output logic             fall_tick
);

  logic [HALF_W-1:0] cnt;
  logic [HALF_W-1:0] half;
  logic              wrap;

  assign half      = HALF_W'(mdc_ratio(sel) / 2);
  assign wrap      = en && (cnt == half - HALF_W'(1));
  assign rise_tick = wrap && !mdc;
  assign fall_tick = wrap && mdc;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + HALF_W'(1);
    end
  end

  // R1
  mdc_low_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !mdc);

  // R2
  half_cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    en |-> (cnt < half));

endmodule

// File: rtl/mdio_frame.sv
module mdio_frame #(
  parameter int PHY_AW  = 5,
  parameter int REG_AW  = 5,
  parameter int DATA_W  = 16,
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_wr,
  input  logic              start_rd,
  input  logic [PHY_AW-1:0] phy_addr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              mdio_i,
  input  logic              mdc,
  input  logic              rise_tick,
  input  logic              fall_tick,
  output logic              busy,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [DATA_W-1:0] rdata
);

  localparam int FRAME_LEN = PRE_LEN + 4 + PHY_AW + REG_AW + 2 + DATA_W;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam int TA_POS    = PRE_LEN + 4 + PHY_AW + REG_AW;
  localparam int DATA_POS  = TA_POS + 2;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);
  localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(TA_POS);
  localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(DATA_POS);

  logic [FRAME_LEN-1:0] shreg;
  logic [FRAME_LEN-1:0] frame_init;
  logic [IDX_W-1:0]     bit_idx;
  logic [IDX_W-1:0]     next_idx;
  logic [DATA_W-1:0]    rd_sh;
  logic                 is_rd;

  assign next_idx = bit_idx + IDX_W'(1);

  always_comb begin
    if (start_wr)
      frame_init = {{PRE_LEN{1'b1}}, 2'b01, 2'b01, phy_addr, reg_addr, 2'b10, wdata};
    else
      frame_init = {{PRE_LEN{1'b1}}, 2'b01, 2'b10, phy_addr, reg_addr, 2'b00, {DATA_W{1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
      is_rd   <= 1'b0;
      bit_idx <= '0;
      shreg   <= '0;
      rd_sh   <= '0;
      rdata   <= '0;
    end else if (!busy) begin
      if (start_wr || start_rd) begin
        busy    <= 1'b1;
        is_rd   <= !start_wr;
        bit_idx <= '0;
        shreg   <= frame_init;
        mdio_o  <= frame_init[FRAME_LEN-1];
        mdio_oe <= 1'b1;
      end
    end else begin
      if (rise_tick && is_rd && (bit_idx >= DATA_IDX))
        rd_sh <= {rd_sh[DATA_W-2:0], mdio_i};
      if (fall_tick) begin
        if (bit_idx == LAST_IDX) begin
          busy    <= 1'b0;
          mdio_oe <= 1'b0;
          mdio_o  <= 1'b0;
          if (is_rd)
            rdata <= rd_sh;
        end else begin
          bit_idx <= next_idx;
          shreg   <= shreg << 1;
          mdio_o  <= shreg[FRAME_LEN-2];
          mdio_oe <= !(is_rd && (next_idx >= TA_IDX));
        end
      end
    end
  end

  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdio_oe);

  // R5
  read_turnaround_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && is_rd && (bit_idx >= TA_IDX)) |-> !mdio_oe);

  // R10
  mdio_stable_high_chk: assert property (@(posedge clk) disable iff (rst)
    (mdc && $past(mdc)) |-> $stable(mdio_o));

endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int PHY_AW  = 5,
  parameter int REG_AW  = 5,
  parameter int DATA_W  = 16,
  parameter int PRE_LEN = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     mgmt_rst,
  input  logic [SEL_W-1:0]         div_sel,
  input  logic [PHY_AW+REG_AW-1:0] phy_reg_addr,
  input  logic                     wr_strobe,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     read_cmd,
  output logic                     busy,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     mdc,
  output logic                     mdio_o,
  output logic                     mdio_oe,
  input  logic                     mdio_i
);

  logic             core_rst;
  logic             rd_q;
  logic             start_wr;
  logic             start_rd;
  logic [SEL_W-1:0] sel_q;
  logic             rise_tick;
  logic             fall_tick;

  assign core_rst = rst || mgmt_rst;
  assign start_wr = wr_strobe && !busy;
  assign start_rd = read_cmd && !rd_q && !busy;

  always_ff @(posedge clk) begin
    if (core_rst) begin
      rd_q  <= 1'b0;
      sel_q <= '0;
    end else begin
      rd_q <= read_cmd;
      if (start_wr || start_rd)
        sel_q <= div_sel;
    end
  end

  mdio_clkgen u_clkgen (
    .clk       (clk),
    .rst       (core_rst),
    .en        (busy),
    .sel       (sel_q),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  mdio_frame #(
    .PHY_AW  (PHY_AW),
    .REG_AW  (REG_AW),
    .DATA_W  (DATA_W),
    .PRE_LEN (PRE_LEN)
  ) u_frame (
    .clk       (clk),
    .rst       (core_rst),
    .start_wr  (start_wr),
    .start_rd  (start_rd),
    .phy_addr  (phy_reg_addr[REG_AW +: PHY_AW]),
    .reg_addr  (phy_reg_addr[REG_AW-1:0]),
    .wdata     (wr_data),
    .mdio_i    (mdio_i),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick),
    .busy      (busy),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .rdata     (rd_data)
  );

  // R9
  mgmt_rst_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mgmt_rst |=> (!busy && !mdc && !mdio_oe));

endmodule

// File: tb/tb_mdio_master.sv
module tb_mdio_master;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mgmt_rst = 1'b0;
  logic [2:0]  div_sel = 3'd0;
  logic [9:0]  phy_reg_addr = '0;
  logic        wr_strobe = 1'b0;
  logic [15:0] wr_data = '0;
  logic        read_cmd = 1'b0;
  logic        busy;
  logic [15:0] rd_data;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  mdio_master dut (
    .clk(clk), .rst(rst), .mgmt_rst(mgmt_rst), .div_sel(div_sel),
    .phy_reg_addr(phy_reg_addr), .wr_strobe(wr_strobe), .wr_data(wr_data),
    .read_cmd(read_cmd), .busy(busy), .rd_data(rd_data), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // PHY model, observed at the falling system-clock edge
  int          rc = 0;
  int          cyc = 0;
  int          rise_cyc = 0;
  int          period = 0;
  int          high_len = 0;
  logic        mdc_prev = 1'b0;
  logic [63:0] cap_o;
  logic [63:0] cap_oe;
  logic [15:0] phy_val = 16'h0000;

  assign mdio_i = (rc >= 48 && rc < 64) ? phy_val[63-rc] : 1'b1;

  always @(negedge clk) begin
    cyc++;
    if (mdc && !mdc_prev) begin
      if (rc < 64) begin
        cap_o[63-rc]  = mdio_o;
        cap_oe[63-rc] = mdio_oe;
      end
      if (rc == 2) period = cyc - rise_cyc;
      rise_cyc = cyc;
      rc++;
    end
    if (!mdc && mdc_prev && rc == 2) high_len = cyc - rise_cyc;
    mdc_prev = mdc;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_frame(input bit rd, input logic [9:0] a, input logic [15:0] d);
    if (rd) exp_frame = {32'hFFFF_FFFF, 2'b01, 2'b10, a, 2'b00, 16'h0};
    else    exp_frame = {32'hFFFF_FFFF, 2'b01, 2'b01, a, 2'b10, d};
  endfunction

  function automatic int ratio_of(input logic [2:0] s);
    case (s)
      3'd0: ratio_of = 4;  3'd1: ratio_of = 6;  3'd2: ratio_of = 8;
      3'd3: ratio_of = 10; 3'd4: ratio_of = 14; 3'd5: ratio_of = 20;
      default: ratio_of = 28;
    endcase
  endfunction

  task automatic wait_idle();
    for (int i = 0; i < 4000 && busy; i++) @(negedge clk);
  endtask

  task automatic do_write(input logic [2:0] s, input logic [9:0] a, input logic [15:0] d);
    @(negedge clk);
    rc = 0; period = 0; high_len = 0;
    div_sel = s; phy_reg_addr = a; wr_data = d; wr_strobe = 1'b1;
    @(negedge clk);
    wr_strobe = 1'b0;
    chk(busy === 1'b1, "R4 busy after strobe", {63'd0, busy}, 64'd1);
    wait_idle();
    chk(busy === 1'b0 && rc == 64, "R4 busy clears after 64 bits", 64'(rc), 64'd64);
    chk(cap_o === exp_frame(0, a, d), "R3 write frame", cap_o, exp_frame(0, a, d));
    chk(cap_oe === '1, "R3 oe for write", cap_oe, '1);
    chk(period == ratio_of(s) && high_len == ratio_of(s) / 2, "R2 mdc period",
        64'(period), 64'(ratio_of(s)));
  endtask

  task automatic do_read(input logic [2:0] s, input logic [9:0] a, input logic [15:0] v);
    @(negedge clk);
    rc = 0; period = 0;
    div_sel = s; phy_reg_addr = a; phy_val = v; read_cmd = 1'b1;
    @(negedge clk);
    chk(busy === 1'b1, "R7 read starts on rise", {63'd0, busy}, 64'd1);
    wait_idle();
    chk(cap_o[63:18] === exp_frame(1, a, 0) >> 18, "R5 read header", 64'(cap_o[63:18]),
        exp_frame(1, a, 0) >> 18);
    chk(cap_oe === {46'h3FFF_FFFF_FFFF, 18'h0}, "R5 oe released", cap_oe,
        {46'h3FFF_FFFF_FFFF, 18'h0});
    chk(rd_data === v, "R6 read data", 64'(rd_data), 64'(v));
  endtask

  task automatic t_reset();
    chk(mdc === 0 && mdio_oe === 0 && busy === 0 && rd_data === 0, "R1 reset state",
        {mdc, mdio_oe, busy, 45'd0, rd_data}, 64'd0);
  endtask

  task automatic t_level_read();
    do_read(3'd1, 10'h2A5, 16'hBEEF);
    repeat (40) @(negedge clk);
    chk(busy === 0 && rc == 64, "R7 held command no restart", 64'(rc), 64'd64);
    read_cmd = 1'b0;
    @(negedge clk);
    do_read(3'd0, 10'h013, 16'h8001);
    read_cmd = 1'b0;
  endtask

  task automatic t_ignore_busy();
    @(negedge clk);
    rc = 0;
    div_sel = 3'd0; phy_reg_addr = 10'h0C3; wr_data = 16'h5A5A; wr_strobe = 1'b1;
    @(negedge clk);
    wr_strobe = 1'b0;
    repeat (60) @(negedge clk);
    phy_reg_addr = 10'h3FF; wr_data = 16'hFFFF; div_sel = 3'd6; wr_strobe = 1'b1; read_cmd = 1'b1;
    @(negedge clk);
    wr_strobe = 1'b0;
    wait_idle();
    chk(cap_o === exp_frame(0, 10'h0C3, 16'h5A5A), "R8 frame unchanged", cap_o,
        exp_frame(0, 10'h0C3, 16'h5A5A));
    repeat (30) @(negedge clk);
    chk(busy === 0 && rc == 64, "R8 no second frame", 64'(rc), 64'd64);
    read_cmd = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_mgmt_rst();
    @(negedge clk);
    div_sel = 3'd2; phy_reg_addr = 10'h111; wr_data = 16'h1234; wr_strobe = 1'b1;
    @(negedge clk);
    wr_strobe = 1'b0;
    repeat (100) @(negedge clk);
    mgmt_rst = 1'b1;
    @(negedge clk);
    chk(busy === 0 && mdc === 0 && mdio_oe === 0, "R9 abort", {61'd0, busy, mdc, mdio_oe}, 64'd0);
    wr_strobe = 1'b1; read_cmd = 1'b1;
    @(negedge clk);
    wr_strobe = 1'b0;
    repeat (5) @(negedge clk);
    chk(busy === 0 && mdc === 0, "R9 commands ignored", {62'd0, busy, mdc}, 64'd0);
    read_cmd = 1'b0;
    mgmt_rst = 1'b0;
    repeat (2) @(negedge clk);
    do_write(3'd3, 10'h155, 16'hC0DE);
  endtask

  task automatic t_priority();
    @(negedge clk);
    rc = 0;
    div_sel = 3'd0; phy_reg_addr = 10'h2F0; wr_data = 16'h0F0F;
    wr_strobe = 1'b1; read_cmd = 1'b1;
    @(negedge clk);
    wr_strobe = 1'b0;
    wait_idle();
    chk(cap_o === exp_frame(0, 10'h2F0, 16'h0F0F), "R4 write priority", cap_o,
        exp_frame(0, 10'h2F0, 16'h0F0F));
    read_cmd = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    do_write(3'd0, 10'h0A1, 16'hA55A);
    do_write(3'd4, 10'h3C7, 16'h1234);
    do_write(3'd7, 10'h201, 16'h8000);
    do_write(3'd5, 10'h0FE, 16'h7FFE);
    t_level_read();
    t_ignore_busy();
    t_mgmt_rst();
    t_priority();
    chk(mdc === 0 && mdio_oe === 0, "R1 idle after frames", {62'd0, mdc, mdio_oe}, 64'd0);
    // R10 stability of mdio_o during MDC high is covered by the embedded property
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule